// File: doc/BRIEF.md
# Host-to-Peripheral Strobe Sequencing Bridge

This block links a host bus to up to four peripheral chips. The host side has an active-low select, a read/not-write level and an active-low output enable. The peripherals need an active-low chip select and separate active-low read and write strobes. Every host control input is resynchronised to the bridge clock. A small sequencer then produces a peripheral access in which the chosen strobe falls only after the chip select is already low, and rises again before the chip select is released.

The upper address bits pick one of the peripheral selects, one-hot. The low address bits pass through as the register address. Host write data often settles only after the select has asserted, so the bridge keeps following the host data for as long as the select is held, and keeps the last value it saw. Read data is registered at the close of the strobe and shown to the host while the host holds its output enable low.

A second host select input gives the choice of two address windows. By default, either select opens an access and the read/not-write level sets its direction. With the split-window option, the first select can only produce writes and the second can only produce reads.

Top module: `strobe_bridge`

## Requirements
- R1: During and straight after reset, all peripheral selects and both strobes are high, `busy` is low and `host_rdata` is zero.
- R2: A host select sampled low on a rising clock edge makes exactly one peripheral select go low on the third rising edge. The index of that select is the address bits above the register field (bits 4:3 by default). `per_addr` carries address bits 2:0.
- R3: The active strobe goes low `SETUP_CLKS` clocks after the peripheral select falls and stays low for `STROBE_CLKS` clocks. The peripheral select rises `HOLD_CLKS` clocks after the strobe rises.
- R4: In the default window mode, a read/not-write level of 0 produces only the write strobe and a level of 1 produces only the read strobe. The two strobes are never low together, and no strobe is low while every peripheral select is high.
- R5: Direction comes from the window. With `SPLIT_WIN=1`, `host_cs_n` produces only writes and `host_rcs_n` produces only reads, whatever `host_rnw` is. With `SPLIT_WIN=0`, `host_rcs_n` opens an access exactly as `host_cs_n` does, and its direction is set by `host_rnw`.
- R6: `per_wdata` follows host write data while the host select is held, so data that arrives late is still taken. After release it keeps the last value sampled under the select, even if the host data changes.
- R7: Read data is registered at the end of the strobe. While the host select is still held, `host_rdata` shows that value when `host_oe_n` is low and shows zero when `host_oe_n` is high.
- R8: Once the host select has been released and the bridge is idle, `host_rdata` returns to zero.
- R9: A host select released before the strobe has started still produces the full, correctly timed access. `busy` is high exactly while a peripheral select is low.
- R10: Holding the host select produces only one access. A release followed by a new assertion while the bridge is busy produces a second access, which starts on the clock after the bridge becomes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host select, first window (active low) |
| host_rcs_n | input | 1 | Host select, second window (active low) |
| host_rnw | input | 1 | Host direction: 1 read, 0 write |
| host_oe_n | input | 1 | Host output enable for read data (active low) |
| host_addr | input | ADDR_W | Host address: select index above register field |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data returned to the host |
| busy | output | 1 | High while a peripheral access is in progress |
| per_cs_n | output | NUM_CS | Peripheral chip selects, one-hot active low |
| per_addr | output | REG_AW | Peripheral register address |
| per_rd_n | output | 1 | Peripheral read strobe (active low) |
| per_wr_n | output | 1 | Peripheral write strobe (active low) |
| per_wdata | output | DATA_W | Write data presented to the peripheral |
| per_rdata | input | DATA_W | Read data from the peripheral |

## Verification
The assertions assume that a host never asserts both window selects at the same time. They also assume that address and direction are steady from the moment a select falls until the bridge has started the access. The bench drives each access with the address and direction fixed before the select falls and held until after release. In split-window mode it asserts only one window at a time. The only input it changes inside an access is the write data, which it changes on purpose to model data that arrives late.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEL  = 2'd1,
      ST_STB  = 2'd2,
      ST_REL  = 2'd3
   } seq_state_t;

   // Width of a down-counter able to hold the largest phase length minus one.
   function automatic int phase_cnt_w(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return (m > 1) ? $clog2(m) : 1;
   endfunction

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
   parameter int   W       = 1,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= {W{RST_VAL}};
         q    <= {W{RST_VAL}};
      end else begin
         meta <= d;
         q    <= meta;
      end
   end

endmodule

// File: rtl/bridge_decode.sv
module bridge_decode #(
   parameter  int NUM_CS = 4,
   parameter  int REG_AW = 3,
   localparam int SEL_W  = $clog2(NUM_CS),
   localparam int ADDR_W = REG_AW + SEL_W
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CS-1:0] cs_n,
   output logic [REG_AW-1:0] reg_addr
);

   assign reg_addr = addr[REG_AW-1:0];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_n[i] = !(en && (addr[ADDR_W-1:REG_AW] == SEL_W'(i)));
   end

endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
   import bridge_pkg::*;
#(
   parameter int SETUP_CLKS  = 1,
   parameter int STROBE_CLKS = 2,
   parameter int HOLD_CLKS   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic req_wr,
   output logic launch,
   output logic cs_phase,
   output logic rd_stb,
   output logic wr_stb,
   output logic stb_end
);

   localparam int CNT_W = phase_cnt_w(SETUP_CLKS, STROBE_CLKS, HOLD_CLKS);

   seq_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic             need_rel;
   logic             kind_wr;

   assign launch   = (st == ST_IDLE) && req && !need_rel;
   assign cs_phase = (st != ST_IDLE);
   assign rd_stb   = (st == ST_STB) && !kind_wr;
   assign wr_stb   = (st == ST_STB) && kind_wr;
   assign stb_end  = (st == ST_STB) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         need_rel <= 1'b0;
         kind_wr  <= 1'b0;
      end else begin
         // re-arm only after the host select has been seen released (R10)
         if (!req)        need_rel <= 1'b0;
         else if (launch) need_rel <= 1'b1;

         unique case (st)
            ST_IDLE: if (launch) begin
               st      <= ST_SEL;
               cnt     <= CNT_W'(SETUP_CLKS - 1);
               kind_wr <= req_wr;
            end
            ST_SEL: if (cnt == '0) begin
               st  <= ST_STB;
               cnt <= CNT_W'(STROBE_CLKS - 1);
            end else cnt <= cnt - 1'b1;
            ST_STB: if (cnt == '0) begin
               st  <= ST_REL;
               cnt <= CNT_W'(HOLD_CLKS - 1);
            end else cnt <= cnt - 1'b1;
            ST_REL: if (cnt == '0) st <= ST_IDLE;
                    else cnt <= cnt - 1'b1;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R3: the strobe phase is only ever entered from the select phase
   assert_stb_from_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STB) && ($past(st) != ST_STB) |-> ($past(st) == ST_SEL));

endmodule

// File: rtl/strobe_bridge.sv
module strobe_bridge #(
   parameter  int DATA_W      = 8,
   parameter  int REG_AW      = 3,
   parameter  int NUM_CS      = 4,
   parameter  int SETUP_CLKS  = 1,
   parameter  int STROBE_CLKS = 2,
   parameter  int HOLD_CLKS   = 1,
   parameter  bit SPLIT_WIN   = 1'b0,
   localparam int SEL_W       = $clog2(NUM_CS),
   localparam int ADDR_W      = REG_AW + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_n,
   input  logic              host_rcs_n,
   input  logic              host_rnw,
   input  logic              host_oe_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              busy,
   output logic [NUM_CS-1:0] per_cs_n,
   output logic [REG_AW-1:0] per_addr,
   output logic              per_rd_n,
   output logic              per_wr_n,
   output logic [DATA_W-1:0] per_wdata,
   input  logic [DATA_W-1:0] per_rdata
);

   // elaboration-time parameter checks
   if (SETUP_CLKS < 1 || STROBE_CLKS < 1 || HOLD_CLKS < 1) begin : g_bad_phase
      $error("strobe_bridge: every phase length must be at least one clock");
   end
   if (NUM_CS < 2 || (1 << SEL_W) != NUM_CS) begin : g_bad_cs
      $error("strobe_bridge: NUM_CS must be a power of two, at least 2");
   end
   if (DATA_W < 1 || REG_AW < 1) begin : g_bad_width
      $error("strobe_bridge: DATA_W and REG_AW must be positive");
   end

   // ---- synchronisers -------------------------------------------------
   logic [2:0]        ctl_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] wdata_s;

   bridge_sync #(.W(3), .RST_VAL(1'b1)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n),
      .d({host_cs_n, host_rcs_n, host_rnw}), .q(ctl_s));

   bridge_sync #(.W(ADDR_W), .RST_VAL(1'b0)) u_sync_addr (
      .clk(clk), .rst_n(rst_n), .d(host_addr), .q(addr_s));

   bridge_sync #(.W(DATA_W), .RST_VAL(1'b0)) u_sync_wdata (
      .clk(clk), .rst_n(rst_n), .d(host_wdata), .q(wdata_s));

   logic cs_s_n, rcs_s_n, rnw_s;
   assign cs_s_n  = ctl_s[2];
   assign rcs_s_n = ctl_s[1];
   assign rnw_s   = ctl_s[0];

   // ---- window selection (R5) -------------------------------------------
   logic req, req_wr;
   if (SPLIT_WIN) begin : g_split
      assign req    = !cs_s_n || !rcs_s_n;
      assign req_wr = !cs_s_n;
   end else begin : g_shared
      assign req    = !cs_s_n || !rcs_s_n;
      assign req_wr = !rnw_s;
   end

   // ---- sequencer ---------------------------------------------------------
   logic launch, cs_phase, rd_stb, wr_stb, stb_end;

   bridge_seq #(
      .SETUP_CLKS(SETUP_CLKS), .STROBE_CLKS(STROBE_CLKS), .HOLD_CLKS(HOLD_CLKS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
      .launch(launch), .cs_phase(cs_phase),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .stb_end(stb_end));

   // ---- address latch and decode (R2) ---------------------------------
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (launch) addr_q <= addr_s;
   end

   bridge_decode #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_dec (
      .en(cs_phase), .addr(addr_q), .cs_n(per_cs_n), .reg_addr(per_addr));

   assign per_rd_n = !rd_stb;
   assign per_wr_n = !wr_stb;
   assign busy     = cs_phase;

   // ---- write data: track while selected, keep last (R6) ---------------
   logic [DATA_W-1:0] wcap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   wcap <= '0;
      else if (req) wcap <= wdata_s;
   end
   assign per_wdata = wcap;

   // ---- read data: capture at strobe end, clear when idle (R7, R8) -----
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rdata_q <= '0;
      else if (rd_stb && stb_end)    rdata_q <= per_rdata;
      else if (!req && !cs_phase)    rdata_q <= '0;
   end
   assign host_rdata = host_oe_n ? '0 : rdata_q;

   // ---- assertions ----------------------------------------------------
   logic any_cs, any_stb;
   assign any_cs  = (per_cs_n != {NUM_CS{1'b1}});
   assign any_stb = !per_rd_n || !per_wr_n;

   assert_stb_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      any_stb |-> any_cs);

   assert_cs_before_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_stb) |-> $past(any_cs));

   assert_stb_before_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(any_cs) |-> $past(!any_stb));

   assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!per_rd_n && !per_wr_n));

   assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~per_cs_n));

   assert_busy_tracks_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy == any_cs);

   assert_wdata_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> $stable(per_wdata));

endmodule

// File: tb/tb_strobe_bridge.sv
`timescale 1ns/1ps
module tb_strobe_bridge;

   localparam int SETUP  = 2;
   localparam int STROBE = 3;
   localparam int HOLD   = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       h_cs_n = 1'b1, h_rcs_n = 1'b1, h_rnw = 1'b1, h_oe_n = 1'b1;
   logic [4:0] h_addr = '0;
   logic [7:0] h_wdata = '0;
   logic [7:0] p_rdata = '0;

   logic [7:0] hrd1, hrd2, pwd1, pwd2;
   logic [3:0] cs1, cs2;
   logic [2:0] pa1, pa2;
   logic       rd1, rd2, wr1, wr2, bz1, bz2;

   int  n_chk = 0, n_err = 0;
   bit  use2 = 1'b0;

   always #2.5 clk = ~clk;

   strobe_bridge #(.DATA_W(8), .REG_AW(3), .NUM_CS(4), .SETUP_CLKS(SETUP),
      .STROBE_CLKS(STROBE), .HOLD_CLKS(HOLD), .SPLIT_WIN(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .host_cs_n(h_cs_n), .host_rcs_n(h_rcs_n),
      .host_rnw(h_rnw), .host_oe_n(h_oe_n), .host_addr(h_addr),
      .host_wdata(h_wdata), .host_rdata(hrd1), .busy(bz1), .per_cs_n(cs1),
      .per_addr(pa1), .per_rd_n(rd1), .per_wr_n(wr1), .per_wdata(pwd1),
      .per_rdata(p_rdata));

   strobe_bridge #(.DATA_W(8), .REG_AW(3), .NUM_CS(4), .SETUP_CLKS(SETUP),
      .STROBE_CLKS(STROBE), .HOLD_CLKS(HOLD), .SPLIT_WIN(1'b1)) dut_split (
      .clk(clk), .rst_n(rst_n), .host_cs_n(h_cs_n), .host_rcs_n(h_rcs_n),
      .host_rnw(h_rnw), .host_oe_n(h_oe_n), .host_addr(h_addr),
      .host_wdata(h_wdata), .host_rdata(hrd2), .busy(bz2), .per_cs_n(cs2),
      .per_addr(pa2), .per_rd_n(rd2), .per_wr_n(wr2), .per_wdata(pwd2),
      .per_rdata(p_rdata));

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic grab(output logic [3:0] c, output logic r, output logic w,
                       output logic [2:0] a, output logic [7:0] wd,
                       output logic [7:0] rd, output logic b);
      if (use2) begin c = cs2; r = rd2; w = wr2; a = pa2; wd = pwd2; rd = hrd2; b = bz2; end
      else      begin c = cs1; r = rd1; w = wr1; a = pa1; wd = pwd1; rd = hrd1; b = bz1; end
   endtask

   task automatic finish_up;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // One host access; samples taken at each falling edge (index i).
   task automatic access(input bit which2, input bit use_rcs, input bit rnw,
                         input logic [4:0] a, input logic [7:0] d_mid,
                         input logic [7:0] d_fin, input int len, input bit oe,
                         input bit exp_wr);
      logic [3:0] c; logic r, w, b; logic [2:0] pa; logic [7:0] wd, rd;
      int t_cf = -1, t_sf = -1, t_sr = -1, t_cr = -1, falls = 0;
      logic [3:0] cs_seen = 4'hF; logic [2:0] pa_seen = '0;
      logic [7:0] rd_at_cr = '0;
      bit seen_rd = 0, seen_wr = 0, other = 0, busy_bad = 0, prev_any = 0;
      use2 = which2;
      @(negedge clk); #1;
      if (use_rcs) h_rcs_n = 1'b0; else h_cs_n = 1'b0;
      h_rnw = rnw; h_addr = a; h_wdata = 8'hEE; h_oe_n = !oe;
      for (int i = 1; i <= 80; i++) begin
         @(negedge clk);
         grab(c, r, w, pa, wd, rd, b);
         if (c != 4'hF && !prev_any) falls++;
         prev_any = (c != 4'hF);
         if (c != 4'hF && t_cf < 0) begin t_cf = i; cs_seen = c; pa_seen = pa; end
         if (c != 4'hF && c != cs_seen) other = 1;
         if ((!r || !w) && t_sf < 0) t_sf = i;
         if (t_sf >= 0 && t_sr < 0 && r && w) t_sr = i;
         if (t_cf >= 0 && t_cr < 0 && c == 4'hF) begin t_cr = i; rd_at_cr = rd; end
         if (!r) seen_rd = 1;
         if (!w) seen_wr = 1;
         if (b !== (c != 4'hF)) busy_bad = 1;
         if (i >= len + 3 && t_cr >= 0 && i >= t_cr + 2) break;
         #1;
         if (i == 1) h_wdata = d_mid;
         if (i == len - 1 && i >= 1) h_wdata = d_fin;
         if (i == len) begin h_cs_n = 1'b1; h_rcs_n = 1'b1; h_wdata = 8'h5A; end
      end
      chk("R2", "select latency", t_cf, 3);
      chk("R2", "select index", {28'd0, cs_seen}, {28'd0, ~(4'b0001 << a[4:3])});
      chk("R2", "register address", {29'd0, pa_seen}, {29'd0, a[2:0]});
      chk("R2", "select changed mid-access", other, 0);
      chk("R3", "setup clocks", t_sf - t_cf, SETUP);
      chk("R3", "strobe width", t_sr - t_sf, STROBE);
      chk("R3", "hold clocks", t_cr - t_sr, HOLD);
      chk(use2 ? "R5" : "R4", "write strobe seen", seen_wr, exp_wr);
      chk(use2 ? "R5" : "R4", "read strobe seen", seen_rd, !exp_wr);
      chk("R9", "busy equals select active", busy_bad, 0);
      chk("R10", "accesses per host select", falls, 1);
      if (exp_wr) chk("R6", "write data after release", {24'd0, wd}, {24'd0, d_fin});
      if (!exp_wr && len >= 10)
         chk("R7", "read data under select", {24'd0, rd_at_cr}, oe ? {24'd0, p_rdata} : 32'd0);
      if (!exp_wr) begin
         #1 h_oe_n = 1'b0;
         @(negedge clk);
         grab(c, r, w, pa, wd, rd, b);
         chk("R8", "read data cleared when idle", {24'd0, rd}, 32'd0);
         #1 h_oe_n = 1'b1;
      end
   endtask

   // watchdog
   initial begin
      #(100000 * 5);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
   end

   initial begin
      logic [3:0] c; logic r, w, b; logic [2:0] pa; logic [7:0] wd, rd;
      int falls, second;
      bit prev_any;
      // R1: reset state, also with output enable low
      h_oe_n = 1'b0;
      repeat (3) @(negedge clk);
      grab(c, r, w, pa, wd, rd, b);
      chk("R1", "selects in reset", {28'd0, c}, 32'hF);
      chk("R1", "strobes in reset", {30'd0, r, w}, 32'h3);
      chk("R1", "busy in reset", b, 0);
      chk("R1", "read data in reset", {24'd0, rd}, 0);
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      grab(c, r, w, pa, wd, rd, b);
      chk("R1", "selects after reset", {28'd0, c}, 32'hF);
      chk("R1", "strobes after reset", {30'd0, r, w}, 32'h3);
      chk("R1", "busy after reset", b, 0);
      chk("R1", "read data after reset", {24'd0, rd}, 0);
      #1 h_oe_n = 1'b1;

      // R2 R3 R4 R6: write sweep over every address
      for (int a = 0; a < 32; a++) begin
         logic [7:0] dv;
         dv = 8'(a * 7 + 3);
         access(1'b0, 1'b0, 1'b0, 5'(a), dv, dv, 10, 1'b0, 1'b1);
      end
      // R2 R3 R4 R7 R8: read sweep over every address
      for (int a = 0; a < 32; a++) begin
         p_rdata = 8'(~(a * 5));
         access(1'b0, 1'b0, 1'b1, 5'(a), 8'h00, 8'h00, 10, 1'b1, 1'b0);
      end
      // R7: output enable high hides read data
      p_rdata = 8'hC3;
      access(1'b0, 1'b0, 1'b1, 5'd13, 8'h00, 8'h00, 12, 1'b0, 1'b0);
      // R6: data changes late in the select, last value kept
      access(1'b0, 1'b0, 1'b0, 5'd6, 8'h11, 8'h9D, 12, 1'b0, 1'b1);
      // R9: early release, read and write
      access(1'b0, 1'b0, 1'b1, 5'd27, 8'h00, 8'h00, 1, 1'b1, 1'b0);
      access(1'b0, 1'b0, 1'b0, 5'd18, 8'h00, 8'h64, 2, 1'b0, 1'b1);
      // R10: long hold gives one access
      access(1'b0, 1'b0, 1'b0, 5'd31, 8'h42, 8'h42, 30, 1'b0, 1'b1);
      // R5: shared mode, second select with direction from rnw
      access(1'b0, 1'b1, 1'b0, 5'd10, 8'h77, 8'h77, 10, 1'b0, 1'b1);
      // R5: split mode, windows fix direction, rnw ignored
      access(1'b1, 1'b0, 1'b1, 5'd21, 8'hA5, 8'hA5, 10, 1'b0, 1'b1);
      p_rdata = 8'h3C;
      access(1'b1, 1'b1, 1'b0, 5'd4, 8'h00, 8'h00, 10, 1'b1, 1'b0);

      // R10: release and reassert while busy gives a second access
      use2 = 1'b0;
      @(negedge clk); #1;
      h_cs_n = 1'b0; h_rnw = 1'b1; h_addr = 5'd9;
      falls = 0; second = -1; prev_any = 0;
      for (int i = 1; i <= 34; i++) begin
         @(negedge clk);
         grab(c, r, w, pa, wd, rd, b);
         if (c != 4'hF && !prev_any) begin
            falls++;
            if (falls == 2) second = i;
         end
         prev_any = (c != 4'hF);
         #1;
         if (i == 1)  h_cs_n = 1'b1;
         if (i == 4)  h_cs_n = 1'b0;
         if (i == 30) h_cs_n = 1'b1;
      end
      chk("R10", "accesses after reselect", falls, 2);
      chk("R10", "second access start", second, 10);

      repeat (4) @(negedge clk);
      finish_up();
   end

endmodule